// File: doc/BRIEF.md
# Two-Wire Register Slave with Turnaround Data Line

This block is the device end of a half-duplex synchronous serial port. The host supplies a serial clock and shares one data line with the device. Every transaction is sixteen clock periods long. The host first sends one direction bit and a 7-bit register address. For a write, the host then sends eight data bits. For a read, the device takes over the line and returns eight data bits. The block turns the line around by itself. It presents the line as a data-out signal and an output-enable signal, so the pad logic outside can build the tri-state driver.

Behind the port is a small register file. It holds a configuration byte (soft reset, power-down and forced-awake), a status byte, two motion delta accumulators that clear when read, several read-only statistic bytes passed in from ports, and a fixed inverse-identity byte. The serial clock and data inputs are synchronized into the system clock domain before their edges are detected. A transaction timer abandons a frame that does not finish in time.

Top module: `sdio_reg_slave`

## Requirements
- R1: A frame is 16 rising serial clock edges, sampled on those rising edges, MSB first. Bit 1 is the direction bit (1 = write, 0 = read), bits 2..8 are the address A6..A0 and bits 9..16 are the data D7..D0. A write takes effect at the 16th rising edge.
- R2: On a read, `sdio_oe` rises after the 8th rising edge and D7 is presented. After each of rising edges 9 to 15 the next lower bit is presented. D0 stays driven after the 16th edge until the next falling serial clock edge, which releases the line.
- R3: Only addresses 0x00-0x07, 0x09, 0x0A and 0x11 are implemented. A write to any other address changes nothing, and a read from any other address returns 0x00.
- R4: The configuration register is at 0x00 and resets to 0x00. Bit 0 drives `force_awake_o`. Bit 7 is a soft reset: it drives `soft_rst_o`, clears itself after RST_LEN cycles, and holds both motion deltas at zero while it is set.
- R5: While bit 6 (power-down, `pd_o`) is set, a write to 0x00 updates bit 6 only and leaves every other bit unchanged.
- R6: Entering power-down releases `sdio_oe` on the next cycle. While in power-down the transaction timer is frozen, so a frame paused for longer than the timeout still completes.
- R7: 0x03 holds X motion and 0x02 holds Y motion, as 8-bit two's complement sums of `mot_dx`/`mot_dy` over cycles with `mot_valid`. The sums saturate at 0x7F and 0x80. A read clears the register, but an increment that arrives in the same cycle as the clear is kept.
- R8: 0x01 reads {3'b000, 4'b0000, `awake_i`} and 0x11 reads 0xFF. Writes to 0x01-0x07, 0x09, 0x0A and 0x11 are ignored.
- R9: 0x04 returns `qual_i`, 0x05 returns `pix_max_i[5:0]` zero-extended, 0x06 returns `pix_min_i[5:0]` zero-extended, 0x07 returns `pix_sum_i`, 0x09 returns `shutter_i[15:8]` and 0x0A returns `shutter_i[7:0]`.
- R10: If the 16th rising edge has not come within TO_CYCLES system clocks of the first rising edge of a frame (power-down off), the bit counter returns to idle and any read drive is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from host, idles high |
| sdio_i | input | 1 | Data line as seen at the pad |
| sdio_o | output | 1 | Data driven by the device during reads |
| sdio_oe | output | 1 | Device drive enable for the data line |
| mot_valid | input | 1 | Motion increment valid this cycle |
| mot_dx | input | 8 | X increment, two's complement |
| mot_dy | input | 8 | Y increment, two's complement |
| awake_i | input | 1 | Awake state reported in status |
| qual_i | input | 8 | Surface quality statistic |
| pix_max_i | input | 8 | Brightest pixel value (low 6 bits used) |
| pix_min_i | input | 8 | Darkest pixel value (low 6 bits used) |
| pix_sum_i | input | 8 | Pixel sum statistic |
| shutter_i | input | 16 | Shutter time |
| pd_o | output | 1 | Power-down bit of the configuration |
| force_awake_o | output | 1 | Forced-awake bit of the configuration |
| soft_rst_o | output | 1 | Soft reset in progress |

## Verification
The bench builds the block with TO_CYCLES = 400, RST_LEN = 16 and two synchronizer stages. The default timeout of millions of cycles is far too long for a short run. At 400 cycles, a complete 256-cycle frame fits easily, while a 600-cycle pause inside a frame expires the timer. The bench can therefore show both that a paused frame is dropped in normal mode and that the same pause survives in power-down. The short soft-reset window lets the bench see `soft_rst_o` high right after the write and then watch the bit clear itself.

// File: rtl/sdio_reg_slave.sv
module sdio_reg_slave #(
  parameter int unsigned TO_CYCLES   = 2160000,
  parameter int unsigned RST_LEN     = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck_i,
  input  logic        sdio_i,
  output logic        sdio_o,
  output logic        sdio_oe,
  input  logic        mot_valid,
  input  logic [7:0]  mot_dx,
  input  logic [7:0]  mot_dy,
  input  logic        awake_i,
  input  logic [7:0]  qual_i,
  input  logic [7:0]  pix_max_i,
  input  logic [7:0]  pix_min_i,
  input  logic [7:0]  pix_sum_i,
  input  logic [15:0] shutter_i,
  output logic        pd_o,
  output logic        force_awake_o,
  output logic        soft_rst_o
);

  localparam int TW = $clog2(TO_CYCLES + 1);
  localparam int RW = $clog2(RST_LEN + 1);

  localparam logic [6:0] A_CFG  = 7'h00;
  localparam logic [6:0] A_STAT = 7'h01;
  localparam logic [6:0] A_DY   = 7'h02;
  localparam logic [6:0] A_DX   = 7'h03;
  localparam logic [6:0] A_QUAL = 7'h04;
  localparam logic [6:0] A_PMAX = 7'h05;
  localparam logic [6:0] A_PMIN = 7'h06;
  localparam logic [6:0] A_PSUM = 7'h07;
  localparam logic [6:0] A_SHH  = 7'h09;
  localparam logic [6:0] A_SHL  = 7'h0A;
  localparam logic [6:0] A_INV  = 7'h11;

  logic [SYNC_STAGES-1:0] sck_sr, dat_sr;
  logic sck_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sr <= '1;
      dat_sr <= '0;
      sck_q  <= 1'b1;
    end else begin
      sck_sr <= {sck_sr[SYNC_STAGES-2:0], sck_i};
      dat_sr <= {dat_sr[SYNC_STAGES-2:0], sdio_i};
      sck_q  <= sck_sr[SYNC_STAGES-1];
    end

  wire sck_s = sck_sr[SYNC_STAGES-1];
  wire din   = dat_sr[SYNC_STAGES-1];
  wire rise  = sck_s & ~sck_q;
  wire fall  = ~sck_s & sck_q;

  logic [3:0]    bcnt;
  logic          busy, rd_act, hold, pd_q;
  logic [14:0]   shin;
  logic [7:0]    shout, cfg, dx, dy, rd_val;
  logic [TW-1:0] tmr;
  logic [RW-1:0] rcnt;

  wire       pd        = cfg[6];
  wire       tmo       = busy && !pd && (tmr == TW'(TO_CYCLES - 1));
  wire       last      = rise && (bcnt == 4'd15);
  wire [6:0] raddr     = {shin[5:0], din};
  wire       rd_start  = rise && (bcnt == 4'd7) && !shin[6];
  wire       wr_commit = last && shin[14];
  wire [6:0] waddr     = shin[13:7];
  wire [7:0] wdata     = {shin[6:0], din};
  wire       pd_entry  = pd && !pd_q;
  wire       clr_x     = rd_start && (raddr == A_DX);
  wire       clr_y     = rd_start && (raddr == A_DY);

  always_comb
    case (raddr)
      A_CFG:   rd_val = cfg;
      A_STAT:  rd_val = {7'b0000000, awake_i};
      A_DY:    rd_val = dy;
      A_DX:    rd_val = dx;
      A_QUAL:  rd_val = qual_i;
      A_PMAX:  rd_val = {2'b00, pix_max_i[5:0]};
      A_PMIN:  rd_val = {2'b00, pix_min_i[5:0]};
      A_PSUM:  rd_val = pix_sum_i;
      A_SHH:   rd_val = shutter_i[15:8];
      A_SHL:   rd_val = shutter_i[7:0];
      A_INV:   rd_val = 8'hFF;
      default: rd_val = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bcnt   <= '0;
      busy   <= 1'b0;
      rd_act <= 1'b0;
      shin   <= '0;
      pd_q   <= 1'b0;
    end else begin
      pd_q <= pd;
      if (tmo) begin
        bcnt   <= '0;
        busy   <= 1'b0;
        rd_act <= 1'b0;
      end else if (rise) begin
        bcnt <= bcnt + 4'd1;
        busy <= (bcnt != 4'd15);
        shin <= {shin[13:0], din};
        if (rd_start) rd_act <= 1'b1;
        else if (last) rd_act <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tmr <= '0;
    else if (!busy || last || tmo) tmr <= '0;
    else if (!pd) tmr <= tmr + TW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sdio_oe <= 1'b0;
      hold    <= 1'b0;
      shout   <= '0;
    end else if (tmo || pd_entry) begin
      sdio_oe <= 1'b0;
      hold    <= 1'b0;
    end else begin
      if (rd_start) begin
        sdio_oe <= 1'b1;
        shout   <= rd_val;
      end else if (rise && rd_act && bcnt != 4'd15) begin
        shout <= {shout[6:0], 1'b0};
      end
      if (last && rd_act) hold <= 1'b1;
      if (fall && hold) begin
        sdio_oe <= 1'b0;
        hold    <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg  <= '0;
      rcnt <= '0;
    end else if (wr_commit && waddr == A_CFG) begin
      if (pd) cfg[6] <= wdata[6];
      else    cfg    <= wdata;
      rcnt <= '0;
    end else if (cfg[7]) begin
      if (rcnt == RW'(RST_LEN - 1)) begin
        cfg[7] <= 1'b0;
        rcnt   <= '0;
      end else begin
        rcnt <= rcnt + RW'(1);
      end
    end

  function automatic logic [7:0] sat_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {a[7], a} + {b[7], b};
    if (s[8] != s[7]) return s[8] ? 8'h80 : 8'h7F;
    return s[7:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dx <= '0;
      dy <= '0;
    end else if (cfg[7]) begin
      dx <= '0;
      dy <= '0;
    end else begin
      dx <= sat_add(clr_x ? 8'h00 : dx, mot_valid ? mot_dx : 8'h00);
      dy <= sat_add(clr_y ? 8'h00 : dy, mot_valid ? mot_dy : 8'h00);
    end

  assign sdio_o        = shout[7];
  assign pd_o          = cfg[6];
  assign force_awake_o = cfg[0];
  assign soft_rst_o    = cfg[7];

endmodule

// File: rtl/sdio_reg_slave_chk.sv
module sdio_reg_slave_chk #(
  parameter int unsigned TO_CYCLES = 2160000,
  parameter int unsigned RST_LEN   = 64,
  parameter int TW = 22,
  parameter int RW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sdio_oe,
  input logic          fall,
  input logic          tmo,
  input logic          pd_entry,
  input logic          busy,
  input logic [7:0]    cfg,
  input logic [7:0]    dx,
  input logic [7:0]    dy,
  input logic [TW-1:0] tmr,
  input logic [RW-1:0] rcnt
);

  a_r10_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tmr < TW'(TO_CYCLES));

  a_r6_pd_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg[6]) |=> !sdio_oe);

  a_r6_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[6] && $past(cfg[6]) && busy && $past(busy)) |-> $stable(tmr));

  a_r5_pd_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[6] && $past(cfg[6])) |-> (cfg[5:0] == $past(cfg[5:0])));

  a_r4_rst_clears_motion: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[7] && $past(cfg[7])) |-> (dx == 8'h00 && dy == 8'h00));

  a_r4_rst_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[7] |-> (rcnt < RW'(RST_LEN)));

  a_r2_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdio_oe) |-> $past(fall || tmo || pd_entry));

endmodule

bind sdio_reg_slave sdio_reg_slave_chk #(
  .TO_CYCLES(TO_CYCLES), .RST_LEN(RST_LEN), .TW(TW), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sdio_oe(sdio_oe), .fall(fall), .tmo(tmo),
  .pd_entry(pd_entry), .busy(busy), .cfg(cfg), .dx(dx), .dy(dy),
  .tmr(tmr), .rcnt(rcnt)
);

// File: tb/sdio_reg_slave_test.sv
module sdio_reg_slave_test;
  localparam int H  = 8;
  localparam int TO = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b1, sdio_h = 1'b1;
  logic sdio_o, sdio_oe;
  logic mv = 1'b0;
  logic [7:0] mdx = '0, mdy = '0;
  logic awake = 1'b1;
  logic [7:0] qual = 8'h9A, pmax = 8'hFF, pmin = 8'hC5, psum = 8'h77;
  logic [15:0] shut = 16'hABCD;
  logic pd_o, fa_o, srst_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int exp_q[$]; string tag_q[$]; int got_q[$];
  event ev_got;

  always #4 clk = ~clk;

  sdio_reg_slave #(.TO_CYCLES(TO), .RST_LEN(16), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdio_i(sdio_h),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .mot_valid(mv), .mot_dx(mdx),
    .mot_dy(mdy), .awake_i(awake), .qual_i(qual), .pix_max_i(pmax),
    .pix_min_i(pmin), .pix_sum_i(psum), .shutter_i(shut),
    .pd_o(pd_o), .force_awake_o(fa_o), .soft_rst_o(srst_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always begin
    @(ev_got);
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      automatic int g = got_q.pop_front();
      automatic int e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(g == e, t, g, e);
    end
  end

  task automatic xfer(input bit wr, input logic [6:0] a, input logic [7:0] d,
                      input int gap, output logic [7:0] got, output logic gap_oe);
    logic [15:0] bits;
    bits = {wr, a, d};
    got = '0;
    gap_oe = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (i == 8 && gap > 0) begin
        repeat (gap) @(negedge clk);
        gap_oe = sdio_oe;
      end
      sck = 1'b0;
      if (wr || i < 8) sdio_h = bits[15-i];
      repeat (H) @(negedge clk);
      if (i >= 8) got[15-i] = sdio_o;
      sck = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] g; logic o;
    xfer(1'b1, a, d, 0, g, o);
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] e, input string tag);
    logic [7:0] g; logic o;
    exp_q.push_back(int'(e)); tag_q.push_back(tag);
    xfer(1'b0, a, 8'h00, 0, g, o);
    got_q.push_back(int'(g));
    ->ev_got;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] x, input logic [7:0] y);
    mdx = x; mdy = y; mv = 1'b1;
    @(negedge clk);
    mv = 1'b0; mdx = '0; mdy = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] g, v1, v2; logic o;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk(sdio_oe == 1'b0, "R2 reset oe", int'(sdio_oe), 0);
    chk({pd_o, fa_o, srst_o} == 3'b000, "R4 reset cfg outputs", int'({pd_o, fa_o, srst_o}), 0);
    rd(7'h00, 8'h00, "R4 cfg reset value");
    rd(7'h01, 8'h01, "R8 status awake");
    rd(7'h11, 8'hFF, "R8 inverse id");
    chk(sdio_oe && sdio_o, "R2 D0 held after read", int'({sdio_oe, sdio_o}), 3);
    sck = 1'b0;
    repeat (6) @(negedge clk);
    chk(sdio_oe == 1'b0, "R2 release on falling edge", int'(sdio_oe), 0);
    sck = 1'b1;
    repeat (TO + 200) @(negedge clk);
    rd(7'h00, 8'h00, "R10 resync after stray edge");

    rd(7'h04, 8'h9A, "R9 quality");
    rd(7'h05, 8'h3F, "R9 max pixel masked");
    rd(7'h06, 8'h05, "R9 min pixel masked");
    rd(7'h07, 8'h77, "R9 pixel sum");
    rd(7'h09, 8'hAB, "R9 shutter high");
    rd(7'h0A, 8'hCD, "R9 shutter low");

    wr(7'h08, 8'h5A);
    rd(7'h08, 8'h00, "R3 unimplemented read zero");
    rd(7'h7F, 8'h00, "R3 high address zero");
    wr(7'h05, 8'h11);
    rd(7'h05, 8'h3F, "R3 R8 write to read-only ignored");
    wr(7'h01, 8'hAA);
    rd(7'h01, 8'h01, "R8 status write ignored");

    wr(7'h00, 8'h25);
    rd(7'h00, 8'h25, "R1 write/read frame order");
    wr(7'h00, 8'h01);
    chk(fa_o == 1'b1, "R4 force awake output", int'(fa_o), 1);

    pulse(8'd5, 8'd0); pulse(8'd3, 8'd0);
    rd(7'h03, 8'd8, "R7 dx accumulate");
    rd(7'h03, 8'd0, "R7 dx cleared by read");
    pulse(8'd0, 8'hFC); pulse(8'd0, 8'hFC); pulse(8'd0, 8'hFC);
    rd(7'h02, 8'hF4, "R7 dy negative sum");
    pulse(8'd100, 8'd0); pulse(8'd100, 8'd0);
    rd(7'h03, 8'h7F, "R7 positive saturation");
    pulse(8'h9C, 8'd0); pulse(8'h9C, 8'd0);
    rd(7'h03, 8'h80, "R7 negative saturation");
    pulse(8'd2, 8'd0);
    wr(7'h03, 8'h55);
    rd(7'h03, 8'h02, "R8 delta write ignored");

    fork
      xfer(1'b0, 7'h02, 8'h00, 0, v1, o);
      begin
        repeat (100) @(negedge clk);
        mdy = 8'd1; mv = 1'b1;
        repeat (60) @(negedge clk);
        mv = 1'b0; mdy = '0;
      end
    join
    repeat (4) @(negedge clk);
    xfer(1'b0, 7'h02, 8'h00, 0, v2, o);
    chk(int'(v1) + int'(v2) == 60, "R7 increment kept across clear", int'(v1) + int'(v2), 60);

    xfer(1'b0, 7'h11, 8'h00, TO + 200, g, o);
    chk(o == 1'b0, "R10 paused read dropped", int'(o), 0);
    repeat (TO + 200) @(negedge clk);
    rd(7'h00, 8'h01, "R10 normal after timeout");

    wr(7'h00, 8'h41);
    chk(pd_o == 1'b1, "R5 power-down set", int'(pd_o), 1);
    wr(7'h00, 8'h40);
    rd(7'h00, 8'h41, "R5 locked bits kept");
    xfer(1'b0, 7'h01, 8'h00, TO + 200, g, o);
    chk(o == 1'b1, "R6 timer frozen in power-down", int'(o), 1);
    chk(g == 8'h01, "R6 paused read completes", int'(g), 1);
    wr(7'h00, 8'h00);
    rd(7'h00, 8'h01, "R5 only bit 6 cleared");

    pulse(8'd7, 8'd0);
    wr(7'h00, 8'h80);
    chk(srst_o == 1'b1, "R4 soft reset active", int'(srst_o), 1);
    repeat (30) @(negedge clk);
    chk(srst_o == 1'b0, "R4 soft reset self clears", int'(srst_o), 0);
    rd(7'h00, 8'h00, "R4 cfg after soft reset");
    rd(7'h03, 8'h00, "R4 deltas cleared by reset");

    repeat (10) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule